// File: doc/BRIEF.md
# Embedded Sync Code Detector

This block sits behind a deserializer that already delivers whole bytes, one per cycle when `inValid` is high. It scans that byte stream for four-byte synchronization codes, each a three-byte preamble followed by a tag byte. The tag names the event: line start, line end, frame start or frame end. It also carries a four-bit channel number. From these codes the block produces level framing signals, `hsync` for lines and `vsync` for frames, and a one-cycle pulse per code kind. It keeps the last channel number seen, and it pulses `byteAlign` so the deserializer can lock its byte boundary.

The parallel data leaves on `outData` qualified by `outValid`. A static select input, `syncStrip`, picks one of two modes. In pass mode every received byte is forwarded, code bytes included, one cycle after it arrives. In strip mode the bytes go through a three-stage delay line, so a preamble can still be turned back into payload when its fourth byte proves not to be a tag. Bytes of a recognised code never reach the output in this mode. Because of the delay line, all payload before a code has already left by the time the framing signals change. All payload after the code leaves with the new framing state in place.

Top module: `syncCodeDetector`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `outValid`, `hsync`, `vsync`, `byteAlign` and all four kind pulses are 0 and `chanId` is 0.
- R2: A code is the valid bytes FFh, 00h, 00h followed by a tag byte whose low nibble is 0 (line start), 1 (line end), 2 (frame start) or 3 (frame end). In the cycle after the tag is accepted, exactly the matching pulse output is 1 for one cycle.
- R3: `hsync` becomes 1 after a line start code and 0 after a line end code, in the same cycle as the pulse. Other codes leave it unchanged.
- R4: `vsync` becomes 1 after a frame start code and 0 after a frame end code, in the same cycle as the pulse. Line codes leave it unchanged.
- R5: `chanId` takes the tag's high nibble (bits 7:4) when a code is detected, and holds that value until the next code.
- R6: `byteAlign` is 1 for exactly the one cycle in which a code's kind pulse is 1.
- R7: With `syncStrip` low, every byte accepted with `inValid` appears on `outData`, with `outValid` high, in the next cycle. Code bytes are included.
- R8: With `syncStrip` high, each non-code byte is output in arrival order on the clock edge of the third valid beat after its own. None of the four bytes of a detected code is ever output.
- R9: A preamble followed by a tag whose low nibble is above 3 is not a code. No pulse, `hsync`, `vsync` or `chanId` change occurs, and in strip mode all four bytes are output as payload.
- R10: An FFh byte always restarts the preamble search. In FFh FFh 00h 00h tag, the code is detected and the first FFh is payload.
- R11: Cycles with `inValid` low do not break a code in progress. In such cycles, and in the cycle after them, `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncStrip | input | 1 | 1: remove code bytes from the data output; 0: forward everything |
| inByte | input | 8 | Received byte |
| inValid | input | 1 | `inByte` is valid this cycle |
| outData | output | 8 | Parallel data out |
| outValid | output | 1 | `outData` holds a new byte |
| hsync | output | 1 | Line active level |
| vsync | output | 1 | Frame active level |
| chanId | output | 4 | Channel number of the latest code |
| lineStartPulse | output | 1 | Line start code seen |
| lineEndPulse | output | 1 | Line end code seen |
| frameStartPulse | output | 1 | Frame start code seen |
| frameEndPulse | output | 1 | Frame end code seen |
| byteAlign | output | 1 | Byte boundary confirmed by a code |

## Verification
The assertions assume that `syncStrip` only changes while reset is held. The bench meets this by setting the mode during a reset between its two phases. The assertions also assume that `inValid` is low during reset, which the bench drives explicitly. Stimulus feeds bytes with gaps inside codes, including overlapping preambles, invalid tags and a code as the first bytes after reset. In strip mode the bench ends each phase with filler bytes, so the delay line's contents can be accounted for.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int BYTE_W   = 8;
  localparam int CHAN_W   = 4;
  localparam int KIND_W   = BYTE_W - CHAN_W;
  localparam int PRE_LEN  = 3;
  localparam int KINDS    = 4;
  localparam int CNT_W    = $clog2(PRE_LEN + 1);
  localparam logic [BYTE_W-1:0] PRE_HEAD = 8'hFF;
  localparam logic [BYTE_W-1:0] PRE_FILL = 8'h00;

  typedef enum logic [1:0] {
    KIND_LINE_START  = 2'd0,
    KIND_LINE_END    = 2'd1,
    KIND_FRAME_START = 2'd2,
    KIND_FRAME_END   = 2'd3
  } codeKind_e;

  typedef struct packed {
    logic              shiftEn;
    logic              codeHit;
    codeKind_e         kind;
    logic [CHAN_W-1:0] chan;
  } ctrlStrobe_t;
endpackage

// File: rtl/scd_control.sv
module scd_control
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  output ctrlStrobe_t       strobe
);
  logic [CNT_W-1:0]  matchCnt;
  logic [CNT_W-1:0]  matchNext;
  logic [KIND_W-1:0] tagLow;
  logic              tagOk;
  logic              hit;

  assign tagLow = inByte[KIND_W-1:0];
  assign tagOk  = (tagLow < KIND_W'(KINDS));

  // preamble tracker: counts matched preamble bytes, FF restarts the search
  always_comb begin
    matchNext = matchCnt;
    hit       = 1'b0;
    if (inValid) begin
      if ((matchCnt == CNT_W'(PRE_LEN)) && tagOk) hit = 1'b1;
      if (inByte == PRE_HEAD)
        matchNext = CNT_W'(1);
      else if ((matchCnt != '0) && (matchCnt != CNT_W'(PRE_LEN)) && (inByte == PRE_FILL))
        matchNext = matchCnt + CNT_W'(1);
      else
        matchNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchCnt <= '0;
    else       matchCnt <= matchNext;
  end

  always_comb begin
    strobe.shiftEn = inValid;
    strobe.codeHit = hit;
    strobe.kind    = codeKind_e'(tagLow[1:0]);
    strobe.chan    = inByte[BYTE_W-1 -: CHAN_W];
  end
endmodule

// File: rtl/scd_datapath.sv
module scd_datapath
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncStrip,
  input  logic [BYTE_W-1:0] inByte,
  input  ctrlStrobe_t       strobe,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              hsync,
  output logic              vsync,
  output logic [CHAN_W-1:0] chanId,
  output logic [KINDS-1:0]  kindPulse,
  output logic              byteAlign
);
  localparam int LAST = PRE_LEN - 1;

  logic [BYTE_W-1:0] stageByte [PRE_LEN];
  logic              stageLive [PRE_LEN];

  // delay line holding candidate preamble bytes in strip mode
  generate
    for (genvar i = 0; i < PRE_LEN; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) begin
            stageByte[i] <= '0;
            stageLive[i] <= 1'b0;
          end else if (strobe.shiftEn && syncStrip) begin
            stageByte[i] <= inByte;
            stageLive[i] <= !strobe.codeHit;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) begin
            stageByte[i] <= '0;
            stageLive[i] <= 1'b0;
          end else if (strobe.shiftEn && syncStrip) begin
            stageByte[i] <= stageByte[i-1];
            stageLive[i] <= stageLive[i-1] && !strobe.codeHit;
          end
        end
      end
    end
  endgenerate

  // output byte register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else if (!strobe.shiftEn) begin
      outValid <= 1'b0;
    end else if (!syncStrip) begin
      outData  <= inByte;
      outValid <= 1'b1;
    end else begin
      outData  <= stageByte[LAST];
      outValid <= stageLive[LAST] && !strobe.codeHit;
    end
  end

  // framing levels, channel latch and event pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      chanId    <= '0;
      kindPulse <= '0;
      byteAlign <= 1'b0;
    end else begin
      kindPulse <= '0;
      byteAlign <= strobe.codeHit;
      if (strobe.codeHit) begin
        chanId    <= strobe.chan;
        kindPulse <= KINDS'(1) << strobe.kind;
        unique case (strobe.kind)
          KIND_LINE_START:  hsync <= 1'b1;
          KIND_LINE_END:    hsync <= 1'b0;
          KIND_FRAME_START: vsync <= 1'b1;
          KIND_FRAME_END:   vsync <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/syncCodeDetector.sv
module syncCodeDetector
  import scd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncStrip,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              hsync,
  output logic              vsync,
  output logic [CHAN_W-1:0] chanId,
  output logic              lineStartPulse,
  output logic              lineEndPulse,
  output logic              frameStartPulse,
  output logic              frameEndPulse,
  output logic              byteAlign
);
  ctrlStrobe_t      strobe;
  logic [KINDS-1:0] kindPulse;

  scd_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .inValid (inValid),
    .strobe  (strobe)
  );

  scd_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .syncStrip (syncStrip),
    .inByte    (inByte),
    .strobe    (strobe),
    .outData   (outData),
    .outValid  (outValid),
    .hsync     (hsync),
    .vsync     (vsync),
    .chanId    (chanId),
    .kindPulse (kindPulse),
    .byteAlign (byteAlign)
  );

  assign lineStartPulse  = kindPulse[KIND_LINE_START];
  assign lineEndPulse    = kindPulse[KIND_LINE_END];
  assign frameStartPulse = kindPulse[KIND_FRAME_START];
  assign frameEndPulse   = kindPulse[KIND_FRAME_END];
endmodule

// File: rtl/syncCodeDetector_chk.sv
module syncCodeDetector_chk (
  input logic       clk,
  input logic       rstN,
  input logic       syncStrip,
  input logic [7:0] inByte,
  input logic       inValid,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       hsync,
  input logic       vsync,
  input logic [3:0] chanId,
  input logic       lineStartPulse,
  input logic       lineEndPulse,
  input logic       frameStartPulse,
  input logic       frameEndPulse,
  input logic       byteAlign
);
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lineStartPulse, lineEndPulse, frameStartPulse, frameEndPulse})); // R2
  AST_HSYNC_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsync) |-> lineStartPulse); // R3
  AST_HSYNC_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsync) |-> lineEndPulse); // R3
  AST_VSYNC_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |-> frameStartPulse); // R4
  AST_VSYNC_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsync) |-> frameEndPulse); // R4
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !byteAlign |-> $stable(chanId)); // R5
  AST_ALIGN_WITH_KIND: assert property (@(posedge clk) disable iff (!rstN)
    byteAlign |-> (lineStartPulse || lineEndPulse || frameStartPulse || frameEndPulse)); // R6
  AST_PASS_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (!syncStrip && inValid) |=> (outValid && (outData == $past(inByte)))); // R7
  AST_STRIP_CODE_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (syncStrip && byteAlign) |-> !outValid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R11
endmodule

bind syncCodeDetector syncCodeDetector_chk u_chk (.*);

// File: tb/test_syncCodeDetector.sv
module test_syncCodeDetector;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncStrip = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       inValid = 1'b0;
  logic [7:0] outData;
  logic       outValid, hsync, vsync, byteAlign;
  logic [3:0] chanId;
  logic       lineStartPulse, lineEndPulse, frameStartPulse, frameEndPulse;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];
  logic [7:0] hist[3];
  logic       modelH, modelV;
  logic [3:0] modelChan;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncCodeDetector i_syncCodeDetector (
    .clk(clk), .rstN(rstN), .syncStrip(syncStrip), .inByte(inByte), .inValid(inValid),
    .outData(outData), .outValid(outValid), .hsync(hsync), .vsync(vsync), .chanId(chanId),
    .lineStartPulse(lineStartPulse), .lineEndPulse(lineEndPulse),
    .frameStartPulse(frameStartPulse), .frameEndPulse(frameEndPulse), .byteAlign(byteAlign)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard of output bytes
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0)
        check(1'b0, syncStrip ? "R8" : "R7", "unexpected output byte", outData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(outData == e, syncStrip ? "R8" : "R7", "output byte", outData, e);
      end
    end
  end

  task automatic sendByte(input logic [7:0] b);
    bit         pre;
    bit         isCode;
    logic [3:0] expPulse;
    string      tag;
    pre    = (hist[0] == 8'hFF) && (hist[1] == 8'h00) && (hist[2] == 8'h00);
    isCode = pre && (b[3:0] < 4);
    tag    = (pre && !isCode) ? "R9" : (isCode ? "R2" : "R10");
    if (!syncStrip) expQ.push_back(b);
    else if (isCode) repeat (3) void'(expQ.pop_back());
    else expQ.push_back(b);
    expPulse = 4'b0;
    if (isCode) begin
      expPulse  = 4'b0001 << b[1:0];
      modelChan = b[7:4];
      case (b[1:0])
        2'd0: modelH = 1'b1;
        2'd1: modelH = 1'b0;
        2'd2: modelV = 1'b1;
        default: modelV = 1'b0;
      endcase
    end
    hist[0] = hist[1];
    hist[1] = hist[2];
    hist[2] = b;
    inByte  = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({frameEndPulse, frameStartPulse, lineEndPulse, lineStartPulse} == expPulse, tag,
          "kind pulses", {frameEndPulse, frameStartPulse, lineEndPulse, lineStartPulse}, expPulse);
    check(byteAlign == isCode, "R6", "byteAlign", byteAlign, isCode);
    check(hsync == modelH, "R3", "hsync", hsync, modelH);
    check(vsync == modelV, "R4", "vsync", vsync, modelV);
    check(chanId == modelChan, "R5", "chanId", chanId, modelChan);
  endtask

  task automatic sendIdle(input int n);
    repeat (n) begin
      @(negedge clk);
      check(!outValid, "R11", "outValid during idle", outValid, 0);
    end
  endtask

  task automatic sendCode(input logic [7:0] tagByte, input bit gaps);
    sendByte(8'hFF); if (gaps) sendIdle(1);
    sendByte(8'h00); if (gaps) sendIdle(2);
    sendByte(8'h00); if (gaps) sendIdle(1);
    sendByte(tagByte);
  endtask

  task automatic doReset(input bit strip);
    inValid = 1'b0;
    rstN = 1'b0;
    syncStrip = strip;
    repeat (3) @(negedge clk);
    check({outValid, hsync, vsync, byteAlign, lineStartPulse, lineEndPulse,
           frameStartPulse, frameEndPulse, chanId} == '0, "R1", "outputs in reset",
          {outValid, hsync, vsync, byteAlign, chanId}, 0);
    rstN = 1'b1;
    expQ.delete();
    for (int i = 0; i < 3; i++) hist[i] = 8'h5A;
    modelH = 1'b0; modelV = 1'b0; modelChan = 4'h0;
    @(negedge clk);
    check({outValid, hsync, vsync, byteAlign, chanId} == '0, "R1", "outputs after reset",
          {outValid, hsync, vsync, byteAlign, chanId}, 0);
  endtask

  task automatic stream();
    sendCode(8'h52, 1'b0);               // R2 frame start, code first after reset
    sendByte(8'h10); sendByte(8'h11);
    sendCode(8'h50, 1'b0);               // R3 line start
    for (int i = 0; i < 6; i++) sendByte(8'h20 + 8'(i));
    sendCode(8'h51, 1'b1);               // R11 gaps inside code, line end
    sendByte(8'h33);
    sendCode(8'h57, 1'b0);               // R9 invalid tag
    sendByte(8'h34);
    sendCode(8'h96, 1'b0);               // R9 invalid tag, other nibble
    sendByte(8'hFF);                     // R10 overlapping preamble
    sendCode(8'hA0, 1'b0);
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h44);   // broken preamble is payload
    sendCode(8'h31, 1'b0);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h01);
    sendCode(8'h73, 1'b0);               // R4 frame end, R5 chan 7
    sendByte(8'h55);
  endtask

  initial begin
    doReset(1'b0);
    stream();                            // R7 pass mode
    sendIdle(3);
    check(expQ.size() == 0, "R7", "pending bytes in pass mode", expQ.size(), 0);
    doReset(1'b1);
    stream();                            // R8 strip mode
    for (int i = 0; i < 3; i++) sendByte(8'hE0 + 8'(i));
    sendIdle(3);
    check(expQ.size() == 3, "R8", "bytes held in delay line", expQ.size(), 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule